// File: doc/BRIEF.md
# Memory-Mapped Chip Select Decoder

A purely combinational decoder for a processor bus with a 16-bit address, where ROM, RAM and an I/O device share one data bus. The top three address bits pick one of eight 8 KiB regions. The lower thirteen bits pass through unchanged as the location inside the chosen device.

Each device gets three active-low lines:

- a chip select, which depends only on the address and the decoder enable;
- an output enable, which also needs the read strobe;
- a write enable, which also needs the write strobe.

The ROM's write enable is never driven low.

Three flags report bad accesses:

- a strobe to unmapped space;
- a write aimed at ROM;
- read and write strobes asserted together. In this case every output enable and write enable is held inactive.

A build-time parameter switches to partial decoding, which looks at only the top two address bits. Each device then appears twice inside its 16 KiB window, so the mirroring can be studied.

Top module: `bus_cs_decoder`

## Requirements
- R1: With complete decoding and enable high, addresses with A15..A13 = 000 drive `rom_cs_n` low, 001 drive `ram_cs_n` low, and 010 drive `io_cs_n` low. All chip selects are active low.
- R2: With complete decoding, A15..A13 = 011 and 100 to 111 (0x6000 to 0xFFFF) leave every chip select high.
- R3: For any input combination, at most one of the three chip selects is low.
- R4: With `dec_en` low, all chip selects, output enables and write enables are high, and all three flags are low, whatever the address and strobes.
- R5: A device's output enable is low exactly when its chip select is low, `rd_n` is low and `wr_n` is high.
- R6: The RAM and I/O write enables are low exactly when the device's chip select is low, `wr_n` is low and `rd_n` is high.
- R7: `offset` always equals A12..A0. For example, address 0x2345 selects RAM with offset 0x0345.
- R8: With partial decoding, only A15..A14 are decoded. Window 00 (0x0000 to 0x3FFF) selects ROM, 01 selects RAM, 10 selects I/O and 11 is unmapped. Each device therefore answers at two mirrored 8 KiB images, for example RAM at both 0x4345 and 0x6345.
- R9: `rom_we_n` never goes low. `rom_wr_err` is high when enable is high, `wr_n` is low and the address maps to ROM.
- R10: `rsvd_acc` is high when enable is high, at least one strobe is low, and the address maps to no device.
- R11: With enable high and both strobes low, `strobe_conflict` is high and every output enable and write enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 16 | Bus address |
| dec_en | input | 1 | Decoder enable, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rom_cs_n | output | 1 | ROM chip select |
| ram_cs_n | output | 1 | RAM chip select |
| io_cs_n | output | 1 | I/O chip select |
| rom_oe_n | output | 1 | ROM output enable |
| ram_oe_n | output | 1 | RAM output enable |
| io_oe_n | output | 1 | I/O output enable |
| rom_we_n | output | 1 | ROM write enable, held high |
| ram_we_n | output | 1 | RAM write enable |
| io_we_n | output | 1 | I/O write enable |
| offset | output | 13 | Location inside the selected device |
| rsvd_acc | output | 1 | Strobe to unmapped space |
| rom_wr_err | output | 1 | Write strobe aimed at ROM |
| strobe_conflict | output | 1 | Read and write strobes both asserted |

## Verification
The assertions are immediate checks on settled combinational values. They assume that all four inputs change together and are never X or Z. The bench therefore drives address, enable and both strobes in a single step on the falling clock edge, from fully defined initial values. It samples the outputs on the following rising edge, by which time no input is in motion. Two instances see the same stimulus, one per decoding mode, so the same address patterns show both the exclusive map and the mirrored one.

// File: rtl/csdec_pkg.sv
package csdec_pkg;

  localparam int NDEV    = 3;
  localparam int IDX_ROM = 0;
  localparam int IDX_RAM = 1;
  localparam int IDX_IO  = 2;

  // devices that accept writes (ROM excluded)
  localparam logic [NDEV-1:0] WRITE_MASK = 3'b110;

  // extract the nb most significant bits of an aw-bit address
  function automatic int unsigned top_bits(input logic [31:0] a,
                                           input int unsigned aw,
                                           input int unsigned nb);
    logic [31:0] shifted;
    logic [31:0] mask;
    shifted = a >> (aw - nb);
    mask    = (32'd1 << nb) - 32'd1;
    return int'(shifted & mask);
  endfunction

  // window index to one-hot device select; both decoding modes share it
  function automatic logic [NDEV-1:0] window_to_sel(input int unsigned win);
    logic [NDEV-1:0] s;
    s = '0;
    case (win)
      0:       s[IDX_ROM] = 1'b1;
      1:       s[IDX_RAM] = 1'b1;
      2:       s[IDX_IO]  = 1'b1;
      default: s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/csdec_region.sv
module csdec_region
  import csdec_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int OFFS_W  = 13,
  parameter bit PARTIAL = 1'b0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NDEV-1:0]   sel_o,
  output logic              rsvd_o,
  output logic [OFFS_W-1:0] offset_o
);
  localparam int FULL_BITS = ADDR_W - OFFS_W;
  // partial decoding drops the lowest block-select bit
  localparam int WIN_BITS  = PARTIAL ? FULL_BITS - 1 : FULL_BITS;

  logic [31:0] addr_ext;
  int unsigned win;

  assign addr_ext = 32'(addr_i);

  always_comb begin
    win    = top_bits(addr_ext, ADDR_W, WIN_BITS);
    sel_o  = window_to_sel(win);
    rsvd_o = (sel_o == '0);
  end

  assign offset_o = addr_i[OFFS_W-1:0];

endmodule

// File: rtl/csdec_fault.sv
module csdec_fault
  import csdec_pkg::*;
(
  input  logic            en_i,
  input  logic            rd_n_i,
  input  logic            wr_n_i,
  input  logic [NDEV-1:0] sel_i,
  input  logic            rsvd_i,
  output logic            rsvd_acc_o,
  output logic            rom_wr_err_o,
  output logic            conflict_o
);
  logic any_strobe;

  assign any_strobe   = ~rd_n_i | ~wr_n_i;
  assign conflict_o   = en_i & ~rd_n_i & ~wr_n_i;
  assign rom_wr_err_o = en_i & ~wr_n_i & sel_i[IDX_ROM];
  assign rsvd_acc_o   = en_i & rsvd_i & any_strobe;

endmodule

// File: rtl/csdec_gate.sv
module csdec_gate
  import csdec_pkg::*;
#(
  parameter int              N      = NDEV,
  parameter logic [NDEV-1:0] WR_OK  = WRITE_MASK
) (
  input  logic [N-1:0] sel_i,
  input  logic         en_i,
  input  logic         rd_n_i,
  input  logic         wr_n_i,
  input  logic         block_i,
  output logic [N-1:0] cs_n_o,
  output logic [N-1:0] oe_n_o,
  output logic [N-1:0] we_n_o
);
  for (genvar g = 0; g < N; g++) begin : g_dev
    logic cs_act;
    assign cs_act    = en_i & sel_i[g];
    assign cs_n_o[g] = ~cs_act;
    assign oe_n_o[g] = ~(cs_act & ~rd_n_i & ~block_i);
    if (WR_OK[g]) begin : g_wr
      assign we_n_o[g] = ~(cs_act & ~wr_n_i & ~block_i);
    end else begin : g_ro
      assign we_n_o[g] = 1'b1;
    end
  end

endmodule

// File: rtl/bus_cs_decoder.sv
module bus_cs_decoder
  import csdec_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int OFFS_W         = 13,
  parameter bit PARTIAL_DECODE = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              dec_en,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic              rom_cs_n,
  output logic              ram_cs_n,
  output logic              io_cs_n,
  output logic              rom_oe_n,
  output logic              ram_oe_n,
  output logic              io_oe_n,
  output logic              rom_we_n,
  output logic              ram_we_n,
  output logic              io_we_n,
  output logic [OFFS_W-1:0] offset,
  output logic              rsvd_acc,
  output logic              rom_wr_err,
  output logic              strobe_conflict
);
  logic [NDEV-1:0] sel;
  logic            rsvd;
  logic [NDEV-1:0] cs_n_v;
  logic [NDEV-1:0] oe_n_v;
  logic [NDEV-1:0] we_n_v;
  logic            conflict;
  logic            rsvd_hit;
  logic            rom_err;

  csdec_region #(
    .ADDR_W (ADDR_W),
    .OFFS_W (OFFS_W),
    .PARTIAL(PARTIAL_DECODE)
  ) region_i (
    .addr_i  (addr),
    .sel_o   (sel),
    .rsvd_o  (rsvd),
    .offset_o(offset)
  );

  csdec_fault fault_i (
    .en_i        (dec_en),
    .rd_n_i      (rd_n),
    .wr_n_i      (wr_n),
    .sel_i       (sel),
    .rsvd_i      (rsvd),
    .rsvd_acc_o  (rsvd_hit),
    .rom_wr_err_o(rom_err),
    .conflict_o  (conflict)
  );

  csdec_gate #(
    .N    (NDEV),
    .WR_OK(WRITE_MASK)
  ) gate_i (
    .sel_i  (sel),
    .en_i   (dec_en),
    .rd_n_i (rd_n),
    .wr_n_i (wr_n),
    .block_i(conflict),
    .cs_n_o (cs_n_v),
    .oe_n_o (oe_n_v),
    .we_n_o (we_n_v)
  );

  assign rom_cs_n        = cs_n_v[IDX_ROM];
  assign ram_cs_n        = cs_n_v[IDX_RAM];
  assign io_cs_n         = cs_n_v[IDX_IO];
  assign rom_oe_n        = oe_n_v[IDX_ROM];
  assign ram_oe_n        = oe_n_v[IDX_RAM];
  assign io_oe_n         = oe_n_v[IDX_IO];
  assign rom_we_n        = we_n_v[IDX_ROM];
  assign ram_we_n        = we_n_v[IDX_RAM];
  assign io_we_n         = we_n_v[IDX_IO];
  assign rsvd_acc        = rsvd_hit;
  assign rom_wr_err      = rom_err;
  assign strobe_conflict = conflict;

  // Settled-value checks relating outputs of separate sub-blocks
  always_comb begin
    a_r3_cs_exclusive: assert ($countones(~cs_n_v) <= 1)
      else $error("R3: more than one chip select active");
    a_r2_rsvd_no_cs: assert (!rsvd_hit || (&cs_n_v))
      else $error("R2: chip select active during unmapped access");
    a_r4_disabled_idle: assert (dec_en ||
        ((&cs_n_v) && (&oe_n_v) && (&we_n_v) && !rsvd_hit && !rom_err && !conflict))
      else $error("R4: activity while decoder disabled");
    a_r11_conflict_blocks: assert (!conflict || ((&oe_n_v) && (&we_n_v)))
      else $error("R11: strobe enabled during conflict");
    a_r9_rom_err_selects_rom: assert (!rom_err || (!cs_n_v[IDX_ROM] && (&we_n_v)))
      else $error("R9: ROM write error without ROM select or with a write enable");
    a_r5_oe_within_cs: assert (((~oe_n_v) & cs_n_v) == '0)
      else $error("R5: output enable without chip select");
    a_r6_we_within_cs: assert (((~we_n_v) & cs_n_v) == '0)
      else $error("R6: write enable without chip select");
  end

endmodule

// File: tb/bus_cs_decoder_tb_top.sv
module bus_cs_decoder_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] addr = 16'h0000;
  logic        en   = 1'b0;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;

  logic f_rom_cs, f_ram_cs, f_io_cs, f_rom_oe, f_ram_oe, f_io_oe;
  logic f_rom_we, f_ram_we, f_io_we, f_rsvd, f_romerr, f_conf;
  logic [12:0] f_off;
  logic p_rom_cs, p_ram_cs, p_io_cs, p_rom_oe, p_ram_oe, p_io_oe;
  logic p_rom_we, p_ram_we, p_io_we, p_rsvd, p_romerr, p_conf;
  logic [12:0] p_off;

  bus_cs_decoder dut_i (
    .addr(addr), .dec_en(en), .rd_n(rd_n), .wr_n(wr_n),
    .rom_cs_n(f_rom_cs), .ram_cs_n(f_ram_cs), .io_cs_n(f_io_cs),
    .rom_oe_n(f_rom_oe), .ram_oe_n(f_ram_oe), .io_oe_n(f_io_oe),
    .rom_we_n(f_rom_we), .ram_we_n(f_ram_we), .io_we_n(f_io_we),
    .offset(f_off), .rsvd_acc(f_rsvd), .rom_wr_err(f_romerr),
    .strobe_conflict(f_conf)
  );

  bus_cs_decoder #(.PARTIAL_DECODE(1'b1)) dut_p (
    .addr(addr), .dec_en(en), .rd_n(rd_n), .wr_n(wr_n),
    .rom_cs_n(p_rom_cs), .ram_cs_n(p_ram_cs), .io_cs_n(p_io_cs),
    .rom_oe_n(p_rom_oe), .ram_oe_n(p_ram_oe), .io_oe_n(p_io_oe),
    .rom_we_n(p_rom_we), .ram_we_n(p_ram_we), .io_we_n(p_io_we),
    .offset(p_off), .rsvd_acc(p_rsvd), .rom_wr_err(p_romerr),
    .strobe_conflict(p_conf)
  );

  typedef struct {
    string       tag;
    logic [15:0] a;
    logic [24:0] exp_full;
    logic [24:0] exp_part;
  } item_t;

  item_t sb_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model written from the requirement list
  // vector: {rom_cs,ram_cs,io_cs,rom_oe,ram_oe,io_oe,rom_we,ram_we,io_we,rsvd,romerr,conf,offset}
  function automatic logic [24:0] model(input logic [15:0] a, input logic e,
                                        input logic r, input logic w, input bit part);
    int dev;
    logic conf, rd, wr;
    logic [2:0] cs, oe, we;
    logic rsv, rerr;
    if (!part) begin
      if (a < 16'h2000)      dev = 0;
      else if (a < 16'h4000) dev = 1;
      else if (a < 16'h6000) dev = 2;
      else                   dev = 3;
    end else begin
      if (a < 16'h4000)      dev = 0;
      else if (a < 16'h8000) dev = 1;
      else if (a < 16'hC000) dev = 2;
      else                   dev = 3;
    end
    rd   = e && !r;
    wr   = e && !w;
    conf = rd && wr;
    for (int k = 0; k < 3; k++) begin
      cs[k] = !(e && dev == k);
      oe[k] = !(!cs[k] && rd && !conf);
      we[k] = (k == 0) ? 1'b1 : !(!cs[k] && wr && !conf);
    end
    rsv  = e && (dev == 3) && (!r || !w);
    rerr = wr && dev == 0;
    return {cs[0], cs[1], cs[2], oe[0], oe[1], oe[2], we[0], we[1], we[2],
            rsv, rerr, conf, a[12:0]};
  endfunction

  task automatic apply(input string tag, input logic [15:0] a, input logic e,
                       input logic r, input logic w);
    item_t it;
    @(negedge clk);
    addr = a; en = e; rd_n = r; wr_n = w;
    it.tag = tag;
    it.a = a;
    it.exp_full = model(a, e, r, w, 1'b0);
    it.exp_part = model(a, e, r, w, 1'b1);
    sb_q.push_back(it);
  endtask

  // Monitor: compare at the rising edge, half a period after the drive
  always @(posedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [24:0] gf, gp;
      it = sb_q.pop_front();
      gf = {f_rom_cs, f_ram_cs, f_io_cs, f_rom_oe, f_ram_oe, f_io_oe,
            f_rom_we, f_ram_we, f_io_we, f_rsvd, f_romerr, f_conf, f_off};
      gp = {p_rom_cs, p_ram_cs, p_io_cs, p_rom_oe, p_ram_oe, p_io_oe,
            p_rom_we, p_ram_we, p_io_we, p_rsvd, p_romerr, p_conf, p_off};
      checks += 2;
      if (gf !== it.exp_full) begin
        errors++;
        $display("FAIL %s complete-decode addr=%h actual=%b expected=%b",
                 it.tag, it.a, gf, it.exp_full);
      end
      if (gp !== it.exp_part) begin
        errors++;
        $display("FAIL %s partial-decode addr=%h actual=%b expected=%b",
                 it.tag, it.a, gp, it.exp_part);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state after reset, decoder disabled
    apply("R4", 16'h0000, 1'b0, 1'b1, 1'b1);
    apply("R4", 16'h2345, 1'b0, 1'b0, 1'b1);
    apply("R4", 16'h4000, 1'b0, 1'b1, 1'b0);
    apply("R4", 16'h9000, 1'b0, 1'b0, 1'b0);
    // R1 map boundaries, no strobe
    apply("R1", 16'h0000, 1'b1, 1'b1, 1'b1);
    apply("R1", 16'h1FFF, 1'b1, 1'b1, 1'b1);
    apply("R1", 16'h2000, 1'b1, 1'b1, 1'b1);
    apply("R1", 16'h3FFF, 1'b1, 1'b1, 1'b1);
    apply("R1", 16'h4000, 1'b1, 1'b1, 1'b1);
    apply("R1", 16'h5FFF, 1'b1, 1'b1, 1'b1);
    // R7 worked address
    apply("R7", 16'h2345, 1'b1, 1'b0, 1'b1);
    // R5 reads per device
    apply("R5", 16'h0ABC, 1'b1, 1'b0, 1'b1);
    apply("R5", 16'h3001, 1'b1, 1'b0, 1'b1);
    apply("R5", 16'h5555, 1'b1, 1'b0, 1'b1);
    // R6 writes
    apply("R6", 16'h2FFE, 1'b1, 1'b1, 1'b0);
    apply("R6", 16'h4002, 1'b1, 1'b1, 1'b0);
    // R9 write into ROM space
    apply("R9", 16'h1234, 1'b1, 1'b1, 1'b0);
    apply("R9", 16'h0000, 1'b1, 1'b1, 1'b0);
    // R2 / R10 unmapped space
    apply("R2", 16'h6000, 1'b1, 1'b1, 1'b1);
    apply("R10", 16'h7FFF, 1'b1, 1'b0, 1'b1);
    apply("R10", 16'h8000, 1'b1, 1'b1, 1'b0);
    apply("R10", 16'hFFFF, 1'b1, 1'b0, 1'b1);
    apply("R2", 16'hC000, 1'b1, 1'b1, 1'b1);
    // R11 both strobes
    apply("R11", 16'h2100, 1'b1, 1'b0, 1'b0);
    apply("R11", 16'h4100, 1'b1, 1'b0, 1'b0);
    apply("R11", 16'h0100, 1'b1, 1'b0, 1'b0);
    apply("R11", 16'hE100, 1'b1, 1'b0, 1'b0);
    // R8 mirrored images under partial decoding
    apply("R8", 16'h4345, 1'b1, 1'b0, 1'b1);
    apply("R8", 16'h6345, 1'b1, 1'b0, 1'b1);
    apply("R8", 16'h2345, 1'b1, 1'b1, 1'b0);
    apply("R8", 16'hA345, 1'b1, 1'b1, 1'b0);
    apply("R8", 16'hE345, 1'b1, 1'b0, 1'b1);
    // R3 sweep over all regions and strobe patterns
    for (int i = 0; i < 256; i++) begin
      apply("R3", 16'(i * 16'd257), 1'(i[7] | i[0]), 1'(i[1]), 1'(i[2]));
    end
    wait (sb_q.size() == 0);
    @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule